// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This unit carries out the three control-and-status-register access operations of a processor core: swap, set-bits and clear-bits. Each request gives an operation code, a 12-bit register address, a source operand, a flag saying whether the source register is non-zero, and the current privilege level. The unit turns every operation into a write value and a write mask. The register's new contents are `(old & ~mask) | (value & mask)`. The unit returns the value the register held before the access.

A small bank of example registers sits inside the unit. Each register has a fixed address. The address itself encodes two access rules:
- bits [9:8] give the lowest privilege allowed to touch the register;
- bits [11:10] equal to `2'b11` mark the register read-only.

An access that fails any rule is answered with an illegal-instruction flag, and no state changes. Each request is accepted in one clock cycle. Its response, including the write request that was committed, appears on the registered outputs in the next cycle.

Default bank (index: address, reset value):
- 0: `0x040`, `0x0`
- 1: `0x140`, `0xA0`
- 2: `0x340`, `0x0`
- 3: `0xF11`, `0x489` (read-only)

Operation codes: `00` swap, `01` set-bits, `10` clear-bits, `11` reserved. Privilege codes: `0` user, `1` supervisor, `3` machine.

Top module: `csr_rmw_unit`

## Requirements
- R1: Swap (op `00`) uses the source as write value and an all-ones mask. It returns the old contents and leaves the register equal to the source.
- R2: Set-bits (op `01`) uses an all-ones write value and the source as mask, so the new contents are `old | src`.
- R3: Clear-bits (op `10`) uses a zero write value and the source as mask, so the new contents are `old & ~src`.
- R4: For set-bits and clear-bits with `src_nz_i` = 0, the mask is zero and `wr_valid_o` stays low. The register is unchanged, and the old value is still returned.
- R5: An address matching no bank register is refused with `rsp_illegal_o` = 1.
- R6: An access with `priv_i` numerically below address bits [9:8] is refused.
- R7: A register whose address bits [11:10] are `2'b11` is read-only. Any access to it with a non-zero mask is refused, and a zero-mask access is allowed and returns its value.
- R8: The reserved operation code `11` is refused.
- R9: A refused access returns `rdata_o` = 0 and `wr_valid_o` = 0, and changes no register.
- R10: `rsp_valid_o` is high in exactly the cycle after each cycle with `req_valid_i` high, and low otherwise. `wr_valid_o` is high only for an accepted access with a non-zero mask, and in that case `wr_val_o` and `wr_mask_o` carry the value and mask.
- R11: After reset `rsp_valid_o` is 0 and each register holds its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request this cycle |
| op_i | input | 2 | Operation code |
| addr_i | input | 12 | Register address |
| src_i | input | 32 | Source operand |
| src_nz_i | input | 1 | Source register is not the zero register |
| priv_i | input | 2 | Current privilege level |
| rsp_valid_o | output | 1 | Response valid |
| rsp_illegal_o | output | 1 | Access refused, illegal instruction |
| rdata_o | output | 32 | Register value before the access |
| wr_valid_o | output | 1 | Write committed |
| wr_val_o | output | 32 | Committed write value |
| wr_mask_o | output | 32 | Committed write mask |

## Verification
The bench targets these corner cases, each paired with the wrong behaviour it would expose:
- Set and clear with the zero-source flag low but a non-zero operand. A design that ignores the flag would modify the register.
- A zero-mask read of the read-only register next to a masked write to it. A design that refuses every read-only access would fail the read; one that never refuses would let the write through.
- Privilege just below and at each register's level. A wrong comparison direction would show up at one of these points.
- Unmapped addresses and the reserved operation code. A wrong design would alter some register here; that change is caught by a later read-back.

Random mixes of operands with all-ones, zero and random patterns, against a bench model, catch a wrong merge formula or a swapped value and mask.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  typedef enum logic [1:0] {
    OP_SWAP = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_RSVD = 2'd3
  } csr_op_e;
endpackage

// File: rtl/csr_rmw_opgen.sv
module csr_rmw_opgen
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  csr_op_e         op_i,
  input  logic [XLEN-1:0] src_i,
  input  logic            src_nz_i,
  output logic [XLEN-1:0] val_o,
  output logic [XLEN-1:0] mask_o,
  output logic            op_bad_o
);
  always_comb begin
    val_o    = '0;
    mask_o   = '0;
    op_bad_o = 1'b0;
    unique case (op_i)
      OP_SWAP: begin
        val_o  = src_i;
        mask_o = '1;
      end
      OP_SET: begin
        val_o  = '1;
        mask_o = src_nz_i ? src_i : '0;
      end
      OP_CLR: begin
        val_o  = '0;
        mask_o = src_nz_i ? src_i : '0;
      end
      default: op_bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/csr_rmw_guard.sv
module csr_rmw_guard (
  input  logic [3:0] cls_i,   // addr[11:8]: [3:2] access kind, [1:0] min privilege
  input  logic [1:0] priv_i,
  input  logic       hit_i,
  input  logic       mask_nz_i,
  input  logic       op_bad_i,
  output logic       illegal_o
);
  logic ro;
  logic low_priv;

  assign ro        = (cls_i[3:2] == 2'b11);
  assign low_priv  = (priv_i < cls_i[1:0]);
  assign illegal_o = op_bad_i | ~hit_i | low_priv | (ro & mask_nz_i);
endmodule

// File: rtl/csr_rmw_file.sv
module csr_rmw_file #(
  parameter int XLEN    = 32,
  parameter int ADDR_W  = 12,
  parameter int NUM_CSR = 4,
  parameter logic [NUM_CSR-1:0][ADDR_W-1:0] CSR_ADDR = {12'hF11, 12'h340, 12'h140, 12'h040},
  parameter logic [NUM_CSR-1:0][XLEN-1:0]   CSR_RST  = {32'h0000_0489, 32'h0, 32'h0000_00A0, 32'h0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [XLEN-1:0]   wval_i,
  input  logic [XLEN-1:0]   wmask_i,
  output logic              hit_o,
  output logic [XLEN-1:0]   rdata_o
);
  logic [NUM_CSR-1:0]           hit;
  logic [NUM_CSR-1:0][XLEN-1:0] cur;

  for (genvar i = 0; i < NUM_CSR; i++) begin : g_csr
    localparam logic IS_RO = (CSR_ADDR[i][ADDR_W-1 -: 2] == 2'b11);
    assign hit[i] = (addr_i == CSR_ADDR[i]);
    if (IS_RO) begin : g_ro
      assign cur[i] = CSR_RST[i];
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cur[i] <= CSR_RST[i];
        else if (we_i && hit[i]) cur[i] <= (cur[i] & ~wmask_i) | (wval_i & wmask_i);
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CSR; i++) begin
      if (hit[i]) rdata_o = rdata_o | cur[i];
    end
  end

  assign hit_o = |hit;
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int ADDR_W  = 12,
  parameter int NUM_CSR = 4,
  parameter logic [NUM_CSR-1:0][ADDR_W-1:0] CSR_ADDR = {12'hF11, 12'h340, 12'h140, 12'h040},
  parameter logic [NUM_CSR-1:0][XLEN-1:0]   CSR_RST  = {32'h0000_0489, 32'h0, 32'h0000_00A0, 32'h0}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic              src_nz_i,
  input  logic [1:0]        priv_i,
  output logic              rsp_valid_o,
  output logic              rsp_illegal_o,
  output logic [XLEN-1:0]   rdata_o,
  output logic              wr_valid_o,
  output logic [XLEN-1:0]   wr_val_o,
  output logic [XLEN-1:0]   wr_mask_o
);
  localparam int CLS_MSB = ADDR_W - 1;

  csr_op_e         op_e;
  logic [XLEN-1:0] val_c, mask_c, old_c;
  logic            op_bad_c, hit_c, illegal_c, we_c;

  assign op_e = csr_op_e'(op_i);

  csr_rmw_opgen #(.XLEN(XLEN)) u_opgen (
    .op_i     (op_e),
    .src_i    (src_i),
    .src_nz_i (src_nz_i),
    .val_o    (val_c),
    .mask_o   (mask_c),
    .op_bad_o (op_bad_c)
  );

  csr_rmw_guard u_guard (
    .cls_i     (addr_i[CLS_MSB -: 4]),
    .priv_i    (priv_i),
    .hit_i     (hit_c),
    .mask_nz_i (|mask_c),
    .op_bad_i  (op_bad_c),
    .illegal_o (illegal_c)
  );

  // commit only accepted accesses that actually touch bits
  assign we_c = req_valid_i & ~illegal_c & (|mask_c);

  csr_rmw_file #(
    .XLEN(XLEN), .ADDR_W(ADDR_W), .NUM_CSR(NUM_CSR),
    .CSR_ADDR(CSR_ADDR), .CSR_RST(CSR_RST)
  ) u_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_c),
    .wval_i  (val_c),
    .wmask_i (mask_c),
    .hit_o   (hit_c),
    .rdata_o (old_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o   <= 1'b0;
      rsp_illegal_o <= 1'b0;
      rdata_o       <= '0;
      wr_valid_o    <= 1'b0;
      wr_val_o      <= '0;
      wr_mask_o     <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      wr_valid_o  <= we_c;
      if (req_valid_i) begin
        rsp_illegal_o <= illegal_c;
        rdata_o       <= illegal_c ? '0 : old_c;
        wr_val_o      <= val_c;
        wr_mask_o     <= mask_c;
      end else begin
        rsp_illegal_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/csr_rmw_unit_chk.sv
module csr_rmw_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [1:0]      op_i,
  input logic [1:0]      need_i,
  input logic            src_nz_i,
  input logic [1:0]      priv_i,
  input logic            rsp_valid_o,
  input logic            rsp_illegal_o,
  input logic [XLEN-1:0] rdata_o,
  input logic            wr_valid_o,
  input logic [XLEN-1:0] wr_mask_o
);
  // R10
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  // R10
  no_spurious_rsp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  // R9
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_illegal_o |-> (!wr_valid_o && rdata_o == '0 && rsp_valid_o));
  // R1
  swap_full_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 2'd0) |=> (rsp_illegal_o || wr_mask_o == '1));
  // R4
  x0_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (op_i == 2'd1 || op_i == 2'd2) && !src_nz_i) |=> !wr_valid_o);
  // R8
  rsvd_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 2'd3) |=> rsp_illegal_o);
  // R6
  low_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && priv_i < need_i) |=> rsp_illegal_o);
endmodule

bind csr_rmw_unit csr_rmw_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_valid_i   (req_valid_i),
  .op_i          (op_i),
  .need_i        (addr_i[ADDR_W-3 -: 2]),
  .src_nz_i      (src_nz_i),
  .priv_i        (priv_i),
  .rsp_valid_o   (rsp_valid_o),
  .rsp_illegal_o (rsp_illegal_o),
  .rdata_o       (rdata_o),
  .wr_valid_o    (wr_valid_o),
  .wr_mask_o     (wr_mask_o)
);

// File: tb/tb_csr_rmw_unit.sv
`timescale 1ns/1ps
module tb_csr_rmw_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [11:0] addr_i = '0;
  logic [31:0] src_i = '0;
  logic        src_nz_i = 1'b0;
  logic [1:0]  priv_i = '0;
  logic        rsp_valid_o, rsp_illegal_o, wr_valid_o;
  logic [31:0] rdata_o, wr_val_o, wr_mask_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [11:0] addrs [4] = '{12'h040, 12'h140, 12'h340, 12'hF11};
  logic [31:0] rstv  [4] = '{32'h0, 32'h0000_00A0, 32'h0, 32'h0000_0489};
  logic [31:0] model [4];

  always #4 clk = ~clk;

  csr_rmw_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .op_i(op_i),
    .addr_i(addr_i), .src_i(src_i), .src_nz_i(src_nz_i), .priv_i(priv_i),
    .rsp_valid_o(rsp_valid_o), .rsp_illegal_o(rsp_illegal_o), .rdata_o(rdata_o),
    .wr_valid_o(wr_valid_o), .wr_val_o(wr_val_o), .wr_mask_o(wr_mask_o)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int find_idx(logic [11:0] a);
    for (int i = 0; i < 4; i++) if (addrs[i] == a) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_mask(logic [1:0] op, logic [31:0] s, logic nz);
    if (op == 2'd0) return '1;
    if (op == 2'd3) return '0;
    return nz ? s : '0;
  endfunction

  function automatic logic [31:0] exp_val(logic [1:0] op, logic [31:0] s);
    if (op == 2'd0) return s;
    if (op == 2'd1) return '1;
    return '0;
  endfunction

  // called at a negedge: drive, wait one cycle, check at next negedge
  task automatic access(logic v, logic [1:0] op, logic [11:0] a, logic [31:0] s,
                        logic nz, logic [1:0] pr);
    int idx;
    logic [31:0] m, val, old;
    logic ill, ro, wv;
    string tag;
    req_valid_i = v; op_i = op; addr_i = a; src_i = s; src_nz_i = nz; priv_i = pr;
    @(negedge clk);
    if (!v) begin
      chk("R10", "idle rsp_valid", {31'b0, rsp_valid_o}, 32'd0);
      chk("R10", "idle wr_valid", {31'b0, wr_valid_o}, 32'd0);
      return;
    end
    idx = find_idx(a);
    m   = exp_mask(op, s, nz);
    val = exp_val(op, s);
    ro  = (a[11:10] == 2'b11);
    ill = (op == 2'd3) || (idx < 0) || (pr < a[9:8]) || (ro && m != 0);
    old = (idx >= 0) ? model[idx] : 32'h0;
    wv  = !ill && (m != 0);
    if (op == 2'd3) tag = "R8";
    else if (idx < 0) tag = "R5";
    else if (pr < a[9:8]) tag = "R6";
    else if (ro) tag = "R7";
    else if (m == 0) tag = "R4";
    else if (op == 2'd0) tag = "R1";
    else if (op == 2'd1) tag = "R2";
    else tag = "R3";
    chk("R10", "rsp_valid", {31'b0, rsp_valid_o}, 32'd1);
    chk(tag, "illegal", {31'b0, rsp_illegal_o}, {31'b0, ill});
    chk(ill ? "R9" : tag, "rdata", rdata_o, ill ? 32'h0 : old);
    chk(ill ? "R9" : "R10", "wr_valid", {31'b0, wr_valid_o}, {31'b0, wv});
    if (wv) begin
      chk(tag, "wr_val", wr_val_o, val);
      chk(tag, "wr_mask", wr_mask_o, m);
      if (!ro) model[idx] = (old & ~m) | (val & m);
    end
  endtask

  task automatic readback(string tag);
    for (int i = 0; i < 4; i++) begin
      access(1'b1, 2'd1, addrs[i], 32'hFFFF_FFFF, 1'b0, 2'd3);
      chk(tag, "readback", rdata_o, model[i]);
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) model[i] = rstv[i];
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset rsp_valid", {31'b0, rsp_valid_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    readback("R11");

    // directed
    access(1'b1, 2'd0, 12'h340, 32'hDEAD_BEEF, 1'b1, 2'd3);   // R1
    access(1'b1, 2'd0, 12'h340, 32'h0000_0000, 1'b0, 2'd3);   // R1 swap ignores flag
    access(1'b1, 2'd1, 12'h140, 32'h0F0F_0000, 1'b1, 2'd1);   // R2
    access(1'b1, 2'd2, 12'h140, 32'h0000_0080, 1'b1, 2'd3);   // R3
    access(1'b1, 2'd1, 12'h040, 32'hFFFF_FFFF, 1'b0, 2'd0);   // R4 set, x0
    access(1'b1, 2'd2, 12'h140, 32'hFFFF_FFFF, 1'b0, 2'd1);   // R4 clear, x0
    access(1'b1, 2'd0, 12'h7C0, 32'h1234_5678, 1'b1, 2'd3);   // R5
    access(1'b1, 2'd0, 12'h140, 32'h1111_1111, 1'b1, 2'd0);   // R6 just below
    access(1'b1, 2'd1, 12'h340, 32'h0000_0001, 1'b1, 2'd1);   // R6
    access(1'b1, 2'd1, 12'hF11, 32'h0000_0001, 1'b0, 2'd3);   // R7 read ok
    access(1'b1, 2'd2, 12'hF11, 32'h0000_0001, 1'b1, 2'd3);   // R7 write refused
    access(1'b1, 2'd0, 12'hF11, 32'h0, 1'b0, 2'd3);           // R7 swap refused
    access(1'b1, 2'd3, 12'h040, 32'hFFFF_FFFF, 1'b1, 2'd3);   // R8
    access(1'b0, 2'd0, 12'h040, 32'h0, 1'b0, 2'd0);           // R10 idle
    readback("R9");

    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic [11:0] a;
      logic [31:0] s;
      logic [1:0]  pr;
      int r = $urandom % 6;
      if (r < 4) a = addrs[r];
      else if (r == 4) a = 12'h7C0;
      else a = 12'($urandom);
      case ($urandom % 4)
        0: s = '0;
        1: s = '1;
        default: s = $urandom;
      endcase
      case ($urandom % 3)
        0: pr = 2'd0;
        1: pr = 2'd1;
        default: pr = 2'd3;
      endcase
      access(($urandom % 8) != 0, 2'($urandom), a, s, 1'($urandom), pr);
    end
    readback("R9");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule